// File: doc/BRIEF.md
# Instruction-Encoding Selector with Banked Trap Vectors

This block sits beside the decode stage of one hart and chooses which of several mutually conflicting instruction-decoder variants is live. A small select register holds the active encoding number; it is decoded into a one-hot enable vector, and each bit is meant to be ANDed into the enable of one decoder variant. Changing the encoding changes nothing but that enable vector. No extension state and no power state is touched.

Each encoding number owns a private copy of the machine, supervisor and secondary-supervisor trap-vector registers. When the select register changes, CSR reads, CSR writes and the exported vector values all move to the bank of the new encoding. A build-time policy sets what happens to the encoding on trap entry. It can keep the encoding, force encoding 0, or load a programmable per-mode default. The pre-trap encoding is saved and brought back on trap return.

Top module: `isa_enc_sel`

## Requirements
- R1: `decEn` always has exactly one bit set, bit k meaning encoding k is active.
- R2: The select CSR (address 0x7C0) is writable at every privilege level. A legal write shows on `decEn` and on reads of 0x7C0 from the next cycle. `csrRdata` follows `csrAddr` combinationally.
- R3: A value of NUM_ENC or more written to the select or to either default CSR is ignored, and the register keeps its old legal value.
- R4: The trap-vector CSRs (0x305 machine, 0x105 supervisor, 0x205 secondary) have one bank per encoding. Reads, writes and `mtvecOut`/`stvecOut`/`bstvecOut` always use the bank of the active encoding, and the other banks keep their contents.
- R5: Privilege encoding is 2'b00 user, 2'b01 supervisor, 2'b11 machine, 2'b10 reserved and given no write rights. The machine vector and the machine default (0x7C1) are written only at 2'b11. The supervisor and secondary vectors and the supervisor default (0x7C2) are written at 2'b01 or 2'b11. All other writes to them are ignored.
- R6: With TRAP_POLICY=0, trap entry leaves the active encoding unchanged.
- R7: With TRAP_POLICY=1, trap entry forces the active encoding to 0.
- R8: With TRAP_POLICY=2, trap entry loads the machine default when `trapToM`=1 and the supervisor default otherwise.
- R9: Trap entry saves the encoding active just before it, and `trapReturn` restores the saved value on the next cycle. A second entry overwrites the saved value.
- R10: `trapEnter` wins over `trapReturn` in the same cycle. Any CSR write presented in a cycle with either trap event is dropped.
- R11: After reset the encoding, the saved encoding and both defaults are 0, and every vector bank entry is 0.
- R12: `trapDone` is high for exactly the cycle after a cycle with `trapEnter` or `trapReturn`.
- R13: A read of any unmapped address returns 0, and a write to one has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrValid | input | 1 | CSR access present |
| csrWrite | input | 1 | Access is a write |
| csrAddr | input | 12 | CSR address |
| csrPriv | input | 2 | Privilege level of the access |
| csrWdata | input | XLEN | Write data |
| csrRdata | output | XLEN | Read data for `csrAddr` |
| trapEnter | input | 1 | Trap entry pulse |
| trapToM | input | 1 | Trap targets machine mode (else supervisor) |
| trapReturn | input | 1 | Trap return pulse |
| trapDone | output | 1 | Trap event took effect |
| decEn | output | NUM_ENC | One-hot decoder enables |
| mtvecOut | output | XLEN | Machine trap vector of active bank |
| stvecOut | output | XLEN | Supervisor trap vector of active bank |
| bstvecOut | output | XLEN | Secondary supervisor trap vector of active bank |

## Verification
Read data is combinational, so it is due in the same cycle as the address and is sampled one time unit after the inputs change. Every state change (encoding, defaults, banks, saved encoding) and `trapDone` becomes visible one edge after the cycle that caused it. The bench therefore drives inputs at the falling edge, checks read data before the next rising edge, updates its model at that rising edge and compares all registered outputs at the following falling edge. Three instances, one per trap policy, share the stimulus and each is compared against its own model.

// File: rtl/isa_enc_pkg.sv
package isa_enc_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  localparam logic [11:0] ADDR_SEL    = 12'h7C0;
  localparam logic [11:0] ADDR_MDEF   = 12'h7C1;
  localparam logic [11:0] ADDR_SDEF   = 12'h7C2;
  localparam logic [11:0] ADDR_MTVEC  = 12'h305;
  localparam logic [11:0] ADDR_STVEC  = 12'h105;
  localparam logic [11:0] ADDR_BSTVEC = 12'h205;

  localparam int POLICY_KEEP   = 0;
  localparam int POLICY_FIXED  = 1;
  localparam int POLICY_SELECT = 2;

  typedef struct packed {
    logic selWr;
    logic mtvecWr;
    logic stvecWr;
    logic bstvecWr;
    logic mDefWr;
    logic sDefWr;
    logic trapIn;
    logic trapOut;
    logic toM;
  } ctrlStrobe_t;

endpackage

// File: rtl/isa_enc_ctrl.sv
module isa_enc_ctrl
  import isa_enc_pkg::*;
(
  input  logic        csrValid,
  input  logic        csrWrite,
  input  logic [11:0] csrAddr,
  input  logic [1:0]  csrPriv,
  input  logic        trapEnter,
  input  logic        trapToM,
  input  logic        trapReturn,
  output ctrlStrobe_t strobe
);

  logic  wrOk;
  logic  privM;
  logic  privS;
  priv_e priv;

  always_comb begin
    priv  = priv_e'(csrPriv);
    privM = (priv == PRIV_M);
    privS = privM || (priv == PRIV_S);
    // trap events take the cycle; any CSR write alongside is dropped
    wrOk  = csrValid && csrWrite && !trapEnter && !trapReturn;

    strobe          = '0;
    strobe.selWr    = wrOk && (csrAddr == ADDR_SEL);
    strobe.mtvecWr  = wrOk && privM && (csrAddr == ADDR_MTVEC);
    strobe.stvecWr  = wrOk && privS && (csrAddr == ADDR_STVEC);
    strobe.bstvecWr = wrOk && privS && (csrAddr == ADDR_BSTVEC);
    strobe.mDefWr   = wrOk && privM && (csrAddr == ADDR_MDEF);
    strobe.sDefWr   = wrOk && privS && (csrAddr == ADDR_SDEF);
    strobe.trapIn   = trapEnter;
    strobe.trapOut  = trapReturn && !trapEnter;
    strobe.toM      = trapToM;
  end

endmodule

// File: rtl/isa_enc_dpath.sv
module isa_enc_dpath
  import isa_enc_pkg::*;
#(
  parameter int NUM_ENC     = 4,
  parameter int ENC_W       = 3,
  parameter int XLEN        = 32,
  parameter int TRAP_POLICY = POLICY_SELECT
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [11:0]         csrAddr,
  input  logic [XLEN-1:0]     csrWdata,
  output logic [XLEN-1:0]     csrRdata,
  output logic [NUM_ENC-1:0]  decEn,
  output logic [XLEN-1:0]     mtvecOut,
  output logic [XLEN-1:0]     stvecOut,
  output logic [XLEN-1:0]     bstvecOut,
  output logic                trapDone
);

  localparam int              IDX_W     = $clog2(NUM_ENC);
  localparam logic [XLEN-1:0] ENC_LIMIT = XLEN'(NUM_ENC);

  logic [ENC_W-1:0] activeEnc;
  logic [ENC_W-1:0] savedEnc;
  logic [ENC_W-1:0] mDefEnc;
  logic [ENC_W-1:0] sDefEnc;
  logic [ENC_W-1:0] trapEnc;
  logic [ENC_W-1:0] wrEnc;
  logic [IDX_W-1:0] activeIdx;
  logic             wrLegal;

  logic [XLEN-1:0] mtvecBank  [NUM_ENC];
  logic [XLEN-1:0] stvecBank  [NUM_ENC];
  logic [XLEN-1:0] bstvecBank [NUM_ENC];

  assign wrLegal   = (csrWdata < ENC_LIMIT);
  assign wrEnc     = csrWdata[ENC_W-1:0];
  assign activeIdx = activeEnc[IDX_W-1:0];

  // encoding chosen on trap entry, picked by the build-time policy
  generate
    if (TRAP_POLICY == POLICY_KEEP) begin : g_keep
      assign trapEnc = activeEnc;
    end else if (TRAP_POLICY == POLICY_FIXED) begin : g_fixed
      assign trapEnc = '0;
    end else begin : g_select
      assign trapEnc = strobe.toM ? mDefEnc : sDefEnc;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeEnc <= '0;
      savedEnc  <= '0;
      trapDone  <= 1'b0;
    end else begin
      trapDone <= strobe.trapIn || strobe.trapOut;
      if (strobe.trapIn) begin
        savedEnc  <= activeEnc;
        activeEnc <= trapEnc;
      end else if (strobe.trapOut) begin
        activeEnc <= savedEnc;
      end else if (strobe.selWr && wrLegal) begin
        activeEnc <= wrEnc;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDefEnc <= '0;
      sDefEnc <= '0;
    end else begin
      if (strobe.mDefWr && wrLegal) mDefEnc <= wrEnc;
      if (strobe.sDefWr && wrLegal) sDefEnc <= wrEnc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENC; e++) begin
        mtvecBank[e]  <= '0;
        stvecBank[e]  <= '0;
        bstvecBank[e] <= '0;
      end
    end else begin
      if (strobe.mtvecWr)  mtvecBank[activeIdx]  <= csrWdata;
      if (strobe.stvecWr)  stvecBank[activeIdx]  <= csrWdata;
      if (strobe.bstvecWr) bstvecBank[activeIdx] <= csrWdata;
    end
  end

  generate
    for (genvar g = 0; g < NUM_ENC; g++) begin : g_dec
      assign decEn[g] = (activeEnc == ENC_W'(g));
    end
  endgenerate

  assign mtvecOut  = mtvecBank[activeIdx];
  assign stvecOut  = stvecBank[activeIdx];
  assign bstvecOut = bstvecBank[activeIdx];

  always_comb begin
    case (csrAddr)
      ADDR_SEL:    csrRdata = XLEN'(activeEnc);
      ADDR_MDEF:   csrRdata = XLEN'(mDefEnc);
      ADDR_SDEF:   csrRdata = XLEN'(sDefEnc);
      ADDR_MTVEC:  csrRdata = mtvecOut;
      ADDR_STVEC:  csrRdata = stvecOut;
      ADDR_BSTVEC: csrRdata = bstvecOut;
      default:     csrRdata = '0;
    endcase
  end

endmodule

// File: rtl/isa_enc_sel.sv
module isa_enc_sel
  import isa_enc_pkg::*;
#(
  parameter int NUM_ENC     = 4,
  parameter int ENC_W       = 3,
  parameter int XLEN        = 32,
  parameter int TRAP_POLICY = POLICY_SELECT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csrValid,
  input  logic               csrWrite,
  input  logic [11:0]        csrAddr,
  input  logic [1:0]         csrPriv,
  input  logic [XLEN-1:0]    csrWdata,
  output logic [XLEN-1:0]    csrRdata,
  input  logic               trapEnter,
  input  logic               trapToM,
  input  logic               trapReturn,
  output logic               trapDone,
  output logic [NUM_ENC-1:0] decEn,
  output logic [XLEN-1:0]    mtvecOut,
  output logic [XLEN-1:0]    stvecOut,
  output logic [XLEN-1:0]    bstvecOut
);

  ctrlStrobe_t strobe;

  isa_enc_ctrl u_ctrl (
    .csrValid   (csrValid),
    .csrWrite   (csrWrite),
    .csrAddr    (csrAddr),
    .csrPriv    (csrPriv),
    .trapEnter  (trapEnter),
    .trapToM    (trapToM),
    .trapReturn (trapReturn),
    .strobe     (strobe)
  );

  isa_enc_dpath #(
    .NUM_ENC     (NUM_ENC),
    .ENC_W       (ENC_W),
    .XLEN        (XLEN),
    .TRAP_POLICY (TRAP_POLICY)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .csrAddr   (csrAddr),
    .csrWdata  (csrWdata),
    .csrRdata  (csrRdata),
    .decEn     (decEn),
    .mtvecOut  (mtvecOut),
    .stvecOut  (stvecOut),
    .bstvecOut (bstvecOut),
    .trapDone  (trapDone)
  );

endmodule

// File: rtl/isa_enc_sel_chk.sv
module isa_enc_sel_chk
  import isa_enc_pkg::*;
#(
  parameter int NUM_ENC     = 4,
  parameter int ENC_W       = 3,
  parameter int XLEN        = 32,
  parameter int TRAP_POLICY = POLICY_SELECT
) (
  input logic               clk,
  input logic               rstN,
  input logic               csrValid,
  input logic               csrWrite,
  input logic [11:0]        csrAddr,
  input logic [1:0]         csrPriv,
  input logic [XLEN-1:0]    csrWdata,
  input logic               trapEnter,
  input logic               trapReturn,
  input logic               trapDone,
  input logic [NUM_ENC-1:0] decEn,
  input logic [XLEN-1:0]    mtvecOut,
  input logic [XLEN-1:0]    stvecOut,
  input logic [XLEN-1:0]    bstvecOut
);

  localparam logic [XLEN-1:0] ENC_LIMIT = XLEN'(NUM_ENC);

  logic anyEvt;
  logic csrWr;
  logic selWrLegal;
  logic selWrIllegal;
  logic mtvecDenied;

  assign anyEvt       = trapEnter || trapReturn;
  assign csrWr        = csrValid && csrWrite && !anyEvt;
  assign selWrLegal   = csrWr && (csrAddr == ADDR_SEL) && (csrWdata < ENC_LIMIT);
  assign selWrIllegal = csrWr && (csrAddr == ADDR_SEL) && !(csrWdata < ENC_LIMIT);
  assign mtvecDenied  = csrWr && (csrAddr == ADDR_MTVEC) && (csrPriv != 2'b11);

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(decEn) == 1);

  a_r2_sel_write: assert property (@(posedge clk) disable iff (!rstN)
    selWrLegal |=> decEn == (NUM_ENC'(1) << $past(csrWdata[ENC_W-1:0])));

  a_r3_warl_sel: assert property (@(posedge clk) disable iff (!rstN)
    selWrIllegal |=> $stable(decEn));

  a_r4_vec_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!(csrValid && csrWrite) && !anyEvt)
      |=> ($stable(mtvecOut) && $stable(stvecOut) && $stable(bstvecOut)));

  a_r5_mtvec_priv: assert property (@(posedge clk) disable iff (!rstN)
    mtvecDenied |=> $stable(mtvecOut));

  a_r6_keep: assert property (@(posedge clk) disable iff (!rstN)
    (TRAP_POLICY == POLICY_KEEP && trapEnter) |=> $stable(decEn));

  a_r7_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (TRAP_POLICY == POLICY_FIXED && trapEnter) |=> decEn[0]);

  a_r12_done_set: assert property (@(posedge clk) disable iff (!rstN)
    anyEvt |=> trapDone);

  a_r12_done_clr: assert property (@(posedge clk) disable iff (!rstN)
    !anyEvt |=> !trapDone);

endmodule

bind isa_enc_sel isa_enc_sel_chk #(
  .NUM_ENC     (NUM_ENC),
  .ENC_W       (ENC_W),
  .XLEN        (XLEN),
  .TRAP_POLICY (TRAP_POLICY)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .csrValid   (csrValid),
  .csrWrite   (csrWrite),
  .csrAddr    (csrAddr),
  .csrPriv    (csrPriv),
  .csrWdata   (csrWdata),
  .trapEnter  (trapEnter),
  .trapReturn (trapReturn),
  .trapDone   (trapDone),
  .decEn      (decEn),
  .mtvecOut   (mtvecOut),
  .stvecOut   (stvecOut),
  .bstvecOut  (bstvecOut)
);

// File: tb/isa_enc_sel_bench.sv
`timescale 1ns/1ps
module isa_enc_sel_bench;

  localparam int NE = 4;
  localparam int EW = 3;
  localparam int XL = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN;
  logic          csrValid, csrWrite;
  logic [11:0]   csrAddr;
  logic [1:0]    csrPriv;
  logic [XL-1:0] csrWdata;
  logic          trapEnter, trapToM, trapReturn;

  logic [XL-1:0] rdQ   [3];
  logic          doneQ [3];
  logic [NE-1:0] decQ  [3];
  logic [XL-1:0] mvQ   [3];
  logic [XL-1:0] svQ   [3];
  logic [XL-1:0] bvQ   [3];

  // index of each array = trap policy of that instance
  isa_enc_sel #(.NUM_ENC(NE), .ENC_W(EW), .XLEN(XL), .TRAP_POLICY(2)) u_isa_enc_sel (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWrite(csrWrite), .csrAddr(csrAddr),
    .csrPriv(csrPriv), .csrWdata(csrWdata), .csrRdata(rdQ[2]), .trapEnter(trapEnter),
    .trapToM(trapToM), .trapReturn(trapReturn), .trapDone(doneQ[2]), .decEn(decQ[2]),
    .mtvecOut(mvQ[2]), .stvecOut(svQ[2]), .bstvecOut(bvQ[2]));

  isa_enc_sel #(.NUM_ENC(NE), .ENC_W(EW), .XLEN(XL), .TRAP_POLICY(0)) u_keep (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWrite(csrWrite), .csrAddr(csrAddr),
    .csrPriv(csrPriv), .csrWdata(csrWdata), .csrRdata(rdQ[0]), .trapEnter(trapEnter),
    .trapToM(trapToM), .trapReturn(trapReturn), .trapDone(doneQ[0]), .decEn(decQ[0]),
    .mtvecOut(mvQ[0]), .stvecOut(svQ[0]), .bstvecOut(bvQ[0]));

  isa_enc_sel #(.NUM_ENC(NE), .ENC_W(EW), .XLEN(XL), .TRAP_POLICY(1)) u_fixed (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWrite(csrWrite), .csrAddr(csrAddr),
    .csrPriv(csrPriv), .csrWdata(csrWdata), .csrRdata(rdQ[1]), .trapEnter(trapEnter),
    .trapToM(trapToM), .trapReturn(trapReturn), .trapDone(doneQ[1]), .decEn(decQ[1]),
    .mtvecOut(mvQ[1]), .stvecOut(svQ[1]), .bstvecOut(bvQ[1]));

  // behavioural reference state, one set per policy
  int            mAct [3];
  int            mSav [3];
  int            mMd  [3];
  int            mSd  [3];
  logic [XL-1:0] mBank [3][NE][3];
  logic          mDone;
  string         mTag [3];

  int vecs = 0;
  int errs = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [XL-1:0] got, input logic [XL-1:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [XL-1:0] mRead(input int p);
    case (csrAddr)
      12'h7C0: return XL'(mAct[p]);
      12'h7C1: return XL'(mMd[p]);
      12'h7C2: return XL'(mSd[p]);
      12'h305: return mBank[p][mAct[p]][0];
      12'h105: return mBank[p][mAct[p]][1];
      12'h205: return mBank[p][mAct[p]][2];
      default: return '0;
    endcase
  endfunction

  function automatic string rdTag();
    case (csrAddr)
      12'h7C0: return "R2 read sel";
      12'h7C1, 12'h7C2: return "R8 read default";
      12'h305, 12'h105, 12'h205: return "R4 read vector";
      default: return "R13 unmapped read";
    endcase
  endfunction

  task automatic mReset();
    for (int p = 0; p < 3; p++) begin
      mAct[p] = 0; mSav[p] = 0; mMd[p] = 0; mSd[p] = 0;
      mTag[p] = "R11 reset";
      for (int e = 0; e < NE; e++)
        for (int k = 0; k < 3; k++) mBank[p][e][k] = '0;
    end
    mDone = 1'b0;
  endtask

  task automatic mStep();
    bit privM, privS, wr, legal;
    privM = (csrPriv == 2'b11);
    privS = privM || (csrPriv == 2'b01);
    wr    = csrValid && csrWrite;
    legal = (csrWdata < XL'(NE));
    mDone = trapEnter || trapReturn;
    for (int p = 0; p < 3; p++) begin
      if (trapEnter) begin
        mSav[p] = mAct[p];
        if (p == 1) mAct[p] = 0;
        else if (p == 2) mAct[p] = trapToM ? mMd[p] : mSd[p];
        mTag[p] = wr ? "R10 write during trap entry" :
                  (p == 0 ? "R6 keep on entry" : (p == 1 ? "R7 fixed on entry" : "R8 default on entry"));
      end else if (trapReturn) begin
        mAct[p] = mSav[p];
        mTag[p] = wr ? "R10 write during return" : "R9 return restores";
      end else if (wr) begin
        mTag[p] = "R4 vector write";
        case (csrAddr)
          12'h7C0: begin
            if (legal) begin mAct[p] = int'(csrWdata); mTag[p] = "R2 sel write"; end
            else mTag[p] = "R3 illegal sel ignored";
          end
          12'h7C1: begin
            if (privM && legal) mMd[p] = int'(csrWdata);
            mTag[p] = legal ? "R5 mdef write" : "R3 illegal default";
          end
          12'h7C2: begin
            if (privS && legal) mSd[p] = int'(csrWdata);
            mTag[p] = legal ? "R5 sdef write" : "R3 illegal default";
          end
          12'h305: begin
            if (privM) mBank[p][mAct[p]][0] = csrWdata; else mTag[p] = "R5 mtvec denied";
          end
          12'h105: begin
            if (privS) mBank[p][mAct[p]][1] = csrWdata; else mTag[p] = "R5 stvec denied";
          end
          12'h205: begin
            if (privS) mBank[p][mAct[p]][2] = csrWdata; else mTag[p] = "R5 bstvec denied";
          end
          default: mTag[p] = "R13 unmapped write";
        endcase
      end else begin
        mTag[p] = "R1 idle";
      end
    end
  endtask

  task automatic compareAll();
    for (int p = 0; p < 3; p++) begin
      chk({mTag[p], " decEn"}, XL'(decQ[p]), XL'(1) << mAct[p]);
      chk({mTag[p], " mtvec"}, mvQ[p], mBank[p][mAct[p]][0]);
      chk({mTag[p], " stvec"}, svQ[p], mBank[p][mAct[p]][1]);
      chk({mTag[p], " bstvec"}, bvQ[p], mBank[p][mAct[p]][2]);
      chk("R12 trapDone", XL'(doneQ[p]), XL'(mDone));
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input bit v, input bit w, input logic [11:0] a, input logic [1:0] pr,
                     input logic [XL-1:0] d, input bit te, input bit tm, input bit tr);
    csrValid = v; csrWrite = w; csrAddr = a; csrPriv = pr; csrWdata = d;
    trapEnter = te; trapToM = tm; trapReturn = tr;
    #1;
    for (int p = 0; p < 3; p++) chk(rdTag(), rdQ[p], mRead(p));
    @(posedge clk);
    mStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic wrCsr(input logic [11:0] a, input logic [1:0] pr, input logic [XL-1:0] d);
    cyc(1, 1, a, pr, d, 0, 0, 0);
  endtask

  task automatic rdCsr(input logic [11:0] a);
    cyc(1, 0, a, 2'b00, '0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    csrValid = 0; csrWrite = 0; csrAddr = '0; csrPriv = '0; csrWdata = '0;
    trapEnter = 0; trapToM = 0; trapReturn = 0;
    mReset();
    repeat (2) @(negedge clk);
    compareAll();                      // R11 reset values
    rstN = 1'b1;

    // R4 bank 0 then bank 2, then back to bank 0
    wrCsr(12'h305, 2'b11, 32'h0000_1000);
    wrCsr(12'h105, 2'b01, 32'h0000_2000);
    wrCsr(12'h7C0, 2'b00, 32'd2);      // R2 from user mode
    rdCsr(12'h305);
    wrCsr(12'h305, 2'b11, 32'hAAAA_0000);
    wrCsr(12'h205, 2'b11, 32'hBBBB_0000);
    wrCsr(12'h7C0, 2'b00, 32'd0);
    rdCsr(12'h305);
    rdCsr(12'h205);
    // R3 illegal select values
    wrCsr(12'h7C0, 2'b01, 32'd5);
    wrCsr(12'h7C0, 2'b11, 32'h8000_0001);
    rdCsr(12'h7C0);
    // R5 denied writes
    wrCsr(12'h305, 2'b01, 32'hDEAD_0000);
    wrCsr(12'h105, 2'b00, 32'hDEAD_0001);
    wrCsr(12'h205, 2'b10, 32'hDEAD_0002);
    wrCsr(12'h7C1, 2'b01, 32'd1);
    // R8 defaults
    wrCsr(12'h7C1, 2'b11, 32'd3);
    wrCsr(12'h7C2, 2'b01, 32'd1);
    wrCsr(12'h7C2, 2'b11, 32'd7);      // R3 illegal default
    rdCsr(12'h7C1);
    rdCsr(12'h7C2);
    // R13 unmapped
    wrCsr(12'h123, 2'b11, 32'h1234_5678);
    rdCsr(12'h123);
    // R6/R7/R8/R9 traps from encoding 2
    wrCsr(12'h7C0, 2'b00, 32'd2);
    cyc(0, 0, 12'h7C0, 2'b00, '0, 1, 1, 0);
    rdCsr(12'h305);
    cyc(0, 0, 12'h7C0, 2'b00, '0, 0, 0, 1);
    cyc(0, 0, 12'h7C0, 2'b00, '0, 1, 0, 0);
    cyc(0, 0, 12'h7C0, 2'b00, '0, 0, 0, 1);
    // R10 priority and dropped writes
    cyc(1, 1, 12'h7C0, 2'b11, 32'd1, 1, 1, 1);
    cyc(1, 1, 12'h305, 2'b11, 32'h5555_5555, 0, 0, 1);
    // R9 nested entry overwrites saved value
    wrCsr(12'h7C0, 2'b00, 32'd1);
    cyc(0, 0, 12'h0, 2'b00, '0, 1, 0, 0);
    cyc(0, 0, 12'h0, 2'b00, '0, 1, 1, 0);
    cyc(0, 0, 12'h0, 2'b00, '0, 0, 0, 1);
    // R12 idle gap
    cyc(0, 0, 12'h0, 2'b00, '0, 0, 0, 0);

    // mixed stimulus
    for (int i = 0; i < 5000; i++) begin
      int r;
      int ai;
      logic [11:0] a;
      logic [XL-1:0] d;
      r  = $urandom_range(0, 99);
      ai = $urandom_range(0, 6);
      case (ai)
        0: a = 12'h7C0; 1: a = 12'h7C1; 2: a = 12'h7C2; 3: a = 12'h305;
        4: a = 12'h105; 5: a = 12'h205; default: a = 12'h3A0;
      endcase
      d = (ai < 3) ? XL'($urandom_range(0, 7)) : XL'($urandom);
      if (r < 7)
        cyc($urandom_range(0, 1) == 1, 1, a, 2'($urandom_range(0, 3)), d,
            1, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
      else if (r < 13)
        cyc(0, 0, a, 2'b00, d, 0, 0, 1);
      else
        cyc($urandom_range(0, 4) != 0, $urandom_range(0, 9) < 6, a,
            2'($urandom_range(0, 3)), d, 0, 0, 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule